// File: doc/BRIEF.md
# Shared Register Read Port Arbiter

This block lets several execution units share one read port of a register file. Each unit asks for its operand by raising a read-release request. A request counts only when the unit is active (busy, or issued this cycle), the decoded instruction actually reads this port, and no read hazard is flagged for the unit. A lowest-index-first picker grants the port to at most one such unit per cycle. The granted unit's operand register number then drives the port address, and the port read enable is raised in the same cycle.

The register file answers one cycle later on a shared data bus. A registered copy of the grant does three things. It becomes the unit's go-read strobe. It steers the bus data to that unit alone. It keeps that unit out of arbitration for the cycle in which its data returns. Each unit's operand register number is captured when the unit issues. On the issue cycle the decoder value passes straight through. Units from several logical port groups can share one port: their request lines are concatenated into the same requester vector. A parameter selects how the port is addressed: a binary index with a single enable bit, or a one-hot enable vector.

Top module: `rd_port_arb`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, go_rd_o is all zero. With no request inputs raised, port_ren_o is also zero.
- R2: At most one bit of go_rd_o is high in any cycle, and at most one unit is granted the port per cycle.
- R3: Among the eligible units, the grant goes to the lowest-numbered one, where unit i is bit i of each per-unit vector.
- R4: Unit i is eligible only when rd_rel_i[i], active_i[i] and rd_en_i[i] are all 1, hazard_i[i] is 0, and go_rd_o[i] is 0. No port enable is raised unless some unit is eligible.
- R5: go_rd_o[i] is high in exactly the cycle after unit i was granted, so the same unit never has go_rd_o high in two consecutive cycles.
- R6: In binary mode (ADDR_MODE = ADDR_BINARY), port_ren_o is one bit and is high when a unit is granted. port_addr_o then carries that unit's operand register number.
- R7: In unary mode (ADDR_MODE = ADDR_UNARY), port_ren_o is NUM_REGS bits wide. When a unit is granted, only bit r is set, where r is that unit's operand register number. port_addr_o stays zero.
- R8: A unit's operand register number is dec_reg_i slice i in the cycle where issue_i[i] is high. In later cycles it is the value captured at the last issue, or zero if the unit has not issued since reset.
- R9: opnd_o slice i equals port_rdata_i while go_rd_o[i] is high, and is zero otherwise.
- R10: When no unit is granted, port_ren_o and port_addr_o are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | NUM_REQ | Per-unit issue strobe |
| dec_reg_i | input | NUM_REQ*REG_W | Per-unit decoded operand register number, unit i at slice i |
| rd_rel_i | input | NUM_REQ | Per-unit read-release request |
| active_i | input | NUM_REQ | Per-unit busy-or-issued flag |
| rd_en_i | input | NUM_REQ | Per-unit decoded read-enable for this port |
| hazard_i | input | NUM_REQ | Per-unit read hazard; blocks the request |
| port_ren_o | output | EN_W | Port read enable: 1 bit in binary mode, NUM_REGS bits in unary mode |
| port_addr_o | output | REG_W | Port binary address; zero in unary mode |
| port_rdata_i | input | DATA_W | Register file read data, valid one cycle after the enable |
| go_rd_o | output | NUM_REQ | Per-unit go-read strobe (delayed grant) |
| opnd_o | output | NUM_REQ*DATA_W | Per-unit operand data, steered from the shared bus |

## Verification
On every cycle the assertions check four things. At most one go-read strobe is high, and no unit gets two strobes back to back. A port enable is raised only when some unit is eligible and is followed by a strobe, and an idle port carries address zero. Operand lanes without a strobe stay at zero. The bench scenarios are needed for the rest. Lowest-index priority, the issue-time pass-through against the latched register number, the exact one-hot pattern in unary mode, and the data that arrives one cycle after the grant can only be shown by comparing each cycle against a model of the requesters and of a registered register file.

// File: rtl/rd_arb_pkg.sv
package rd_arb_pkg;
  typedef enum logic {
    ADDR_BINARY = 1'b0,
    ADDR_UNARY  = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/rd_prio_pick.sv
module rd_prio_pick #(
  parameter int W = 4
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] gnt_o,
  output logic         any_o
);
  // isolate lowest set bit
  assign gnt_o = req_i & (~req_i + {{(W-1){1'b0}}, 1'b1});
  assign any_o = |req_i;
endmodule

// File: rtl/rd_opnd_latch.sv
module rd_opnd_latch #(
  parameter int REG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [REG_W-1:0] dec_reg_i,
  output logic [REG_W-1:0] reg_o
);
  logic [REG_W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      held_q <= '0;
    else if (issue_i) held_q <= dec_reg_i;
  end

  assign reg_o = issue_i ? dec_reg_i : held_q;
endmodule

// File: rtl/rd_addr_mux.sv
module rd_addr_mux #(
  parameter int                     NUM_REQ   = 4,
  parameter int                     NUM_REGS  = 8,
  parameter int                     REG_W     = 3,
  parameter rd_arb_pkg::addr_mode_e ADDR_MODE = rd_arb_pkg::ADDR_BINARY,
  localparam int                    EN_W      = (ADDR_MODE == rd_arb_pkg::ADDR_UNARY) ? NUM_REGS : 1
) (
  input  logic [NUM_REQ-1:0]       gnt_i,
  input  logic [NUM_REQ*REG_W-1:0] reg_i,
  output logic [EN_W-1:0]          ren_o,
  output logic [REG_W-1:0]         addr_o
);
  if (ADDR_MODE == rd_arb_pkg::ADDR_UNARY) begin : g_unary
    always_comb begin
      ren_o = '0;
      for (int i = 0; i < NUM_REQ; i++) begin
        if (gnt_i[i]) ren_o = ren_o | (EN_W'(1) << reg_i[i*REG_W +: REG_W]);
      end
    end
    assign addr_o = '0;
  end else begin : g_binary
    always_comb begin
      addr_o = '0;
      for (int i = 0; i < NUM_REQ; i++) begin
        if (gnt_i[i]) addr_o = addr_o | reg_i[i*REG_W +: REG_W];
      end
    end
    assign ren_o = |gnt_i;
  end
endmodule

// File: rtl/rd_port_arb.sv
module rd_port_arb #(
  parameter int                     NUM_REQ   = 4,
  parameter int                     NUM_REGS  = 8,
  parameter int                     DATA_W    = 16,
  parameter rd_arb_pkg::addr_mode_e ADDR_MODE = rd_arb_pkg::ADDR_BINARY,
  localparam int                    REG_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int                    EN_W      = (ADDR_MODE == rd_arb_pkg::ADDR_UNARY) ? NUM_REGS : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_REQ-1:0]        issue_i,
  input  logic [NUM_REQ*REG_W-1:0]  dec_reg_i,
  input  logic [NUM_REQ-1:0]        rd_rel_i,
  input  logic [NUM_REQ-1:0]        active_i,
  input  logic [NUM_REQ-1:0]        rd_en_i,
  input  logic [NUM_REQ-1:0]        hazard_i,
  output logic [EN_W-1:0]           port_ren_o,
  output logic [REG_W-1:0]          port_addr_o,
  input  logic [DATA_W-1:0]         port_rdata_i,
  output logic [NUM_REQ-1:0]        go_rd_o,
  output logic [NUM_REQ*DATA_W-1:0] opnd_o
);
  logic [NUM_REQ*REG_W-1:0] cur_reg;
  logic [NUM_REQ-1:0]       pick_req, pick_out, gnt;
  logic                     pick_any;
  logic [NUM_REQ-1:0]       dly_gnt_q;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_unit
    rd_opnd_latch #(.REG_W(REG_W)) latch_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .issue_i  (issue_i[i]),
      .dec_reg_i(dec_reg_i[i*REG_W +: REG_W]),
      .reg_o    (cur_reg[i*REG_W +: REG_W])
    );
    assign opnd_o[i*DATA_W +: DATA_W] = dly_gnt_q[i] ? port_rdata_i : '0;
  end

  // a unit whose data is in flight may not re-request
  assign pick_req = rd_rel_i & active_i & rd_en_i & ~dly_gnt_q & ~hazard_i;

  rd_prio_pick #(.W(NUM_REQ)) pick_i (
    .req_i(pick_req),
    .gnt_o(pick_out),
    .any_o(pick_any)
  );

  assign gnt = pick_out & {NUM_REQ{pick_any}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_gnt_q <= '0;
    else         dly_gnt_q <= gnt;
  end

  assign go_rd_o = dly_gnt_q;

  rd_addr_mux #(
    .NUM_REQ  (NUM_REQ),
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .ADDR_MODE(ADDR_MODE)
  ) mux_i (
    .gnt_i (gnt),
    .reg_i (cur_reg),
    .ren_o (port_ren_o),
    .addr_o(port_addr_o)
  );
endmodule

// File: rtl/rd_port_arb_chk.sv
module rd_port_arb_chk #(
  parameter int NUM_REQ = 4,
  parameter int REG_W   = 3,
  parameter int EN_W    = 1,
  parameter int DATA_W  = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_REQ-1:0]        rd_rel_i,
  input logic [NUM_REQ-1:0]        active_i,
  input logic [NUM_REQ-1:0]        rd_en_i,
  input logic [NUM_REQ-1:0]        hazard_i,
  input logic [EN_W-1:0]           port_ren_o,
  input logic [REG_W-1:0]          port_addr_o,
  input logic [NUM_REQ-1:0]        go_rd_o,
  input logic [NUM_REQ*DATA_W-1:0] opnd_o
);
  AST_GO_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(go_rd_o)); // R2

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_rd_o & $past(go_rd_o)) == '0); // R5

  AST_GO_AFTER_REN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_ren_o != '0) |=> (go_rd_o != '0)); // R5

  AST_REN_NEEDS_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_ren_o != '0) |-> ((rd_rel_i & active_i & rd_en_i & ~hazard_i & ~go_rd_o) != '0)); // R4

  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_ren_o == '0) |-> (port_addr_o == '0)); // R10

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_lane
    AST_LANE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !go_rd_o[i] |-> (opnd_o[i*DATA_W +: DATA_W] == '0)); // R9
  end
endmodule

bind rd_port_arb rd_port_arb_chk #(
  .NUM_REQ(NUM_REQ),
  .REG_W  (REG_W),
  .EN_W   (EN_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_rel_i   (rd_rel_i),
  .active_i   (active_i),
  .rd_en_i    (rd_en_i),
  .hazard_i   (hazard_i),
  .port_ren_o (port_ren_o),
  .port_addr_o(port_addr_o),
  .go_rd_o    (go_rd_o),
  .opnd_o     (opnd_o)
);

// File: tb/rd_port_arb_tb_top.sv
module rd_port_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 4;
  localparam int NREGS  = 8;
  localparam int DW     = 16;
  localparam int RW     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0]    issue, rel, act, ren_dec, haz;
  logic [N*RW-1:0] dec;
  logic            ren_b;
  logic [RW-1:0]   addr_b, addr_u;
  logic [NREGS-1:0] ren_u;
  logic [DW-1:0]   rdata_b, rdata_u;
  logic [N-1:0]    go_b, go_u;
  logic [N*DW-1:0] opnd_b, opnd_u;

  int checks = 0;
  int errors = 0;

  rd_port_arb #(.NUM_REQ(N), .NUM_REGS(NREGS), .DATA_W(DW),
                .ADDR_MODE(rd_arb_pkg::ADDR_BINARY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .dec_reg_i(dec),
    .rd_rel_i(rel), .active_i(act), .rd_en_i(ren_dec), .hazard_i(haz),
    .port_ren_o(ren_b), .port_addr_o(addr_b), .port_rdata_i(rdata_b),
    .go_rd_o(go_b), .opnd_o(opnd_b));

  rd_port_arb #(.NUM_REQ(N), .NUM_REGS(NREGS), .DATA_W(DW),
                .ADDR_MODE(rd_arb_pkg::ADDR_UNARY)) dut_u_i (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .dec_reg_i(dec),
    .rd_rel_i(rel), .active_i(act), .rd_en_i(ren_dec), .hazard_i(haz),
    .port_ren_o(ren_u), .port_addr_o(addr_u), .port_rdata_i(rdata_u),
    .go_rd_o(go_u), .opnd_o(opnd_u));

  function automatic logic [DW-1:0] reg_val(input int k);
    return DW'(16'hA000 + k * 16'h0111);
  endfunction

  function automatic int onehot_idx(input logic [NREGS-1:0] v);
    for (int k = 0; k < NREGS; k++) if (v[k]) return k;
    return 0;
  endfunction

  // register file model: registered read
  always_ff @(posedge clk) begin
    rdata_b <= ren_b ? reg_val(int'(addr_b)) : '0;
    rdata_u <= (ren_u != '0) ? reg_val(onehot_idx(ren_u)) : '0;
  end

  // reference model state
  logic [N-1:0]  m_dly = '0;
  logic [RW-1:0] m_lat [N];
  int            m_prev_reg = 0;

  task automatic check(input string tag, input logic [63:0] act_v, input logic [63:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // inputs are set at a negedge; this checks and advances one cycle
  task automatic run_cycle();
    logic [N-1:0]  elig, g;
    logic [RW-1:0] cur [N];
    logic [RW-1:0] gaddr;
    int            gidx;
    #2;
    for (int i = 0; i < N; i++) cur[i] = issue[i] ? dec[i*RW +: RW] : m_lat[i]; // R8
    elig = rel & act & ren_dec & ~haz & ~m_dly;   // R4
    g = '0; gidx = -1;
    for (int i = N-1; i >= 0; i--) if (elig[i]) gidx = i; // R3 lowest first
    if (gidx >= 0) g[gidx] = 1'b1;
    gaddr = (gidx >= 0) ? cur[gidx] : '0;
    check("R5 go_rd binary", 64'(go_b), 64'(m_dly));
    check("R5 go_rd unary", 64'(go_u), 64'(m_dly));
    check("R6 R3 R8 ren binary", 64'(ren_b), 64'(gidx >= 0));
    check("R6 R3 R8 R10 addr binary", 64'(addr_b), 64'(gaddr));
    check("R7 ren unary", 64'(ren_u), (gidx >= 0) ? (64'(1) << gaddr) : 64'(0));
    check("R7 addr unary", 64'(addr_u), 64'(0));
    for (int i = 0; i < N; i++) begin
      check("R9 opnd binary", 64'(opnd_b[i*DW +: DW]), m_dly[i] ? 64'(reg_val(m_prev_reg)) : 64'(0));
      check("R9 opnd unary", 64'(opnd_u[i*DW +: DW]), m_dly[i] ? 64'(reg_val(m_prev_reg)) : 64'(0));
    end
    @(posedge clk);
    m_dly = g;
    m_prev_reg = int'(gaddr);
    for (int i = 0; i < N; i++) if (issue[i]) m_lat[i] = dec[i*RW +: RW];
    @(negedge clk);
  endtask

  task automatic set_all(input logic [N-1:0] r, a, e, h, iss);
    rel = r; act = a; ren_dec = e; haz = h; issue = iss;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < N; i++) m_lat[i] = '0;
    set_all('0, '0, '0, '0, '0);
    dec = '0;
    repeat (3) @(negedge clk);
    check("R1 go_rd in reset", 64'(go_b), 64'(0));
    check("R1 ren in reset", 64'(ren_b), 64'(0));
    check("R1 unary ren in reset", 64'(ren_u), 64'(0));
    rst_n = 1'b1;
    run_cycle(); // R1 first cycle after reset: model expects zeros

    // all eligible: alternates 0,1,0,1 because go_rd masks unit 0 (R3 R5)
    dec = {3'd7, 3'd5, 3'd3, 3'd2};
    set_all('1, '1, '1, '0, '1);
    run_cycle();
    issue = '0; dec = '0;
    repeat (4) run_cycle();

    // hazard on 0 and 1 leaves unit 2 (R4)
    set_all('1, '1, '1, 4'b0011, '0);
    repeat (2) run_cycle();
    // missing read-enable or active blocks a unit (R4)
    set_all(4'b1111, 4'b1110, 4'b0111, '0, '0);
    repeat (2) run_cycle();

    // issue-time pass-through versus latched copy (R8)
    set_all(4'b0100, 4'b0100, 4'b0100, '0, 4'b0100);
    dec = {3'd0, 3'd6, 3'd0, 3'd0};
    run_cycle();
    set_all(4'b0000, 4'b0100, 4'b0100, '0, '0);
    dec = {3'd0, 3'd1, 3'd0, 3'd0};
    repeat (2) run_cycle();
    set_all(4'b0100, 4'b0100, 4'b0100, '0, '0);
    run_cycle();
    set_all('0, '0, '0, '0, '0);
    run_cycle(); // idle port (R10)

    // constrained random
    for (int c = 0; c < 400; c++) begin
      rel     = N'($urandom) | N'($urandom);
      act     = N'($urandom) | N'($urandom);
      ren_dec = ~(N'($urandom) & N'($urandom));
      haz     = N'($urandom) & N'($urandom) & N'($urandom);
      issue   = N'($urandom) & N'($urandom);
      dec     = (N*RW)'($urandom);
      run_cycle();
    end

    set_all('0, '0, '0, '0, '0);
    run_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule